// File: doc/BRIEF.md
# Programmable Timing Signal Distributor

This block takes a bus of sixteen single-ended timing strobes from a backplane and drives sixteen clean timing outputs to the processing devices on a card. The outputs form four identical copies of a four-signal set, and each copy feeds one column of downstream devices. Every position in the set picks its source from its own fixed group of four backplane inputs, or it is forced to a constant level. A host writes one 16-bit control word that holds these choices. The host can read that word back.

The path from the backplane to the outputs goes through two pipeline stages and then an output register. The latency is therefore fixed, and software can compensate for it by moving the clock phase. The block also produces a capture-monitor strobe, taken from timing input 10 or from an auxiliary input selected by a control bit. It also produces delayed copies of all sixteen raw timing inputs. Both are aligned cycle for cycle with the distributed outputs.

Top module: `ts_distributor`

## Requirements
- R1: Outputs hq_out[k], hq_out[k+4], hq_out[k+8] and hq_out[k+12] always hold the same value, for k = 0..3.
- R2: With its force bit clear, set position n copies one timing input chosen by its 2-bit select code (codes 00, 01, 10, 11 in that order). Set 0 chooses from inputs 1, 2, 9, 10. Set 1 chooses from 3, 4, 11, 12. Set 2 chooses from 5, 6, 13, 14. Set 3 chooses from 7, 0, 15, 8.
- R3: Control word layout: bits [4n+1:4n] hold the select code of set n and bit 4n+2 holds its force bit. A write with cfg_we high is captured at the clock edge and reads back on cfg_rdata from the next cycle. A new value steers the outputs from the second clock edge after the write edge.
- R4: With the force bit of set n set, that set's outputs equal bit 4n+1 of the control word (0 gives low, 1 gives high), whatever the timing inputs do.
- R5: A change on ts_in before clock edge t appears on hq_out just after edge t+2. That is three register stages.
- R6: Control bit 15 picks the capture-monitor strobe: 0 takes timing input 10 and 1 takes aux_in. The strobe has the same three-stage latency as hq_out.
- R7: int_ts_out carries ts_in delayed by exactly three clock edges, aligned with hq_out.
- R8: During and after reset the control word reads 0 and all outputs are low, until inputs propagate. After reset every set selects its first input with force off.
- R9: Control bits 3, 7 and 11 are stored and read back but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that runs the pipeline |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to be written |
| cfg_rdata | output | 16 | Current control word |
| ts_in | input | 16 | Backplane timing inputs |
| aux_in | input | 1 | Auxiliary input, alternate capture-monitor source |
| hq_out | output | 16 | Distributed timing outputs, four replicas of a 4-signal set |
| cap_mon_out | output | 1 | Capture-monitor strobe, aligned with hq_out |
| int_ts_out | output | 16 | Raw timing inputs delayed to match hq_out |

## Verification
The assertions assume that every input is sampled synchronously with clk, is stable at each edge, and holds a known value from the first edge after reset. The checker counts three edges after reset before it compares any pipelined value. The stimulus changes ts_in, aux_in and the write port only just after a rising edge, and it holds all inputs at zero during reset. It sweeps every select code and force setting of every set with random inputs, and it sets the unused bits and bit 15 at random.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    // Per-set control field, LSB first: select code, force, spare
    typedef struct packed {
        logic       spare;
        logic       frc;
        logic [1:0] sel;
    } set_cfg_t;

    localparam int SET_CFG_W = $bits(set_cfg_t);

    // Source input for a set position and a select code.
    // Low half: inputs 2n+1+code[0] wrapped in the half. High half: same plus half.
    function automatic int src_idx(input int set_n, input int code, input int half);
        int lo;
        lo = (2 * set_n + 1 + (code % 2)) % half;
        return (code >= 2) ? (lo + half) : lo;
    endfunction

endpackage

// File: rtl/tsd_cfg_reg.sv
module tsd_cfg_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.word;
endmodule

// File: rtl/tsd_set_mux.sv
module tsd_set_mux
    import tsd_pkg::*;
#(
    parameter int SET_IDX = 0,
    parameter int TS_W    = 16
) (
    input  logic [TS_W-1:0] ts,
    input  set_cfg_t        cfg,
    output logic            bit_out
);
    localparam int HALF = TS_W / 2;

    logic [3:0] cand;

    for (genvar c = 0; c < 4; c++) begin : g_cand
        localparam int IDX = src_idx(SET_IDX, c, HALF);
        assign cand[c] = ts[IDX];
    end

    always_comb begin
        if (cfg.frc) begin
            bit_out = cfg.sel[1];
        end else begin
            bit_out = cand[cfg.sel];
        end
    end
endmodule

// File: rtl/ts_distributor.sv
module ts_distributor
    import tsd_pkg::*;
#(
    parameter int N_SETS  = 4,
    parameter int N_REPL  = 4,
    parameter int MON_IDX = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [SET_CFG_W*N_SETS-1:0] cfg_wdata,
    output logic [SET_CFG_W*N_SETS-1:0] cfg_rdata,
    input  logic [N_SETS*N_REPL-1:0]   ts_in,
    input  logic                       aux_in,
    output logic [N_SETS*N_REPL-1:0]   hq_out,
    output logic                       cap_mon_out,
    output logic [N_SETS*N_REPL-1:0]   int_ts_out
);
    localparam int TS_W    = N_SETS * N_REPL;
    localparam int CFG_W   = SET_CFG_W * N_SETS;
    localparam int MON_BIT = CFG_W - 1;

    typedef struct packed {
        logic            aux;
        logic [TS_W-1:0] ts;
    } s1_t;

    typedef struct packed {
        logic              cap;
        logic [TS_W-1:0]   ts;
        logic [N_SETS-1:0] set_bit;
    } s2_t;

    typedef struct packed {
        logic            cap;
        logic [TS_W-1:0] ts;
        logic [TS_W-1:0] hq;
    } out_t;

    typedef struct packed {
        s1_t  s1;
        s2_t  s2;
        out_t o;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [CFG_W-1:0]  cfg_q;
    logic [N_SETS-1:0] set_bit;

    tsd_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        tsd_set_mux #(.SET_IDX(s), .TS_W(TS_W)) u_mux (
            .ts      (pipe_q.s1.ts),
            .cfg     (set_cfg_t'(cfg_q[SET_CFG_W*s +: SET_CFG_W])),
            .bit_out (set_bit[s])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        // stage 1: capture backplane inputs
        pipe_d.s1.ts  = ts_in;
        pipe_d.s1.aux = aux_in;
        // stage 2: source selection and strobe choice
        pipe_d.s2.set_bit = set_bit;
        pipe_d.s2.ts      = pipe_q.s1.ts;
        pipe_d.s2.cap     = cfg_q[MON_BIT] ? pipe_q.s1.aux : pipe_q.s1.ts[MON_IDX];
        // output register: replicate the set into every column
        for (int r = 0; r < N_REPL; r++) begin
            for (int k = 0; k < N_SETS; k++) begin
                pipe_d.o.hq[r*N_SETS + k] = pipe_q.s2.set_bit[k];
            end
        end
        pipe_d.o.ts  = pipe_q.s2.ts;
        pipe_d.o.cap = pipe_q.s2.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign cfg_rdata   = cfg_q;
    assign hq_out      = pipe_q.o.hq;
    assign int_ts_out  = pipe_q.o.ts;
    assign cap_mon_out = pipe_q.o.cap;
endmodule

// File: rtl/ts_distributor_chk.sv
module ts_distributor_chk #(
    parameter int N_SETS  = 4,
    parameter int N_REPL  = 4,
    parameter int MON_IDX = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [4*N_SETS-1:0]       cfg_wdata,
    input logic [4*N_SETS-1:0]       cfg_rdata,
    input logic [N_SETS*N_REPL-1:0]  ts_in,
    input logic                      aux_in,
    input logic [N_SETS*N_REPL-1:0]  hq_out,
    input logic                      cap_mon_out,
    input logic [N_SETS*N_REPL-1:0]  int_ts_out
);
    localparam int TS_W  = N_SETS * N_REPL;
    localparam int CFG_W = 4 * N_SETS;
    localparam int HALF  = TS_W / 2;

    function automatic int chk_idx(input int n, input logic [1:0] c);
        int v;
        v = (2 * n + 1 + (c[0] ? 1 : 0)) & (HALF - 1);
        if (c[1]) v = v | HALF;
        return v;
    endfunction

    logic [1:0]       age;
    logic [CFG_W-1:0] cfg_p1, cfg_p2;
    logic [TS_W-1:0]  ts_p1, ts_p2, ts_p3;
    logic             aux_p1, aux_p2, aux_p3;
    logic             ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age    <= '0;
            cfg_p1 <= '0;
            cfg_p2 <= '0;
            ts_p1  <= '0;
            ts_p2  <= '0;
            ts_p3  <= '0;
            aux_p1 <= 1'b0;
            aux_p2 <= 1'b0;
            aux_p3 <= 1'b0;
        end else begin
            if (age != 2'd3) age <= age + 2'd1;
            cfg_p1 <= cfg_rdata;
            cfg_p2 <= cfg_p1;
            ts_p1  <= ts_in;
            ts_p2  <= ts_p1;
            ts_p3  <= ts_p2;
            aux_p1 <= aux_in;
            aux_p2 <= aux_p1;
            aux_p3 <= aux_p2;
        end
    end

    assign ready = (age == 2'd3);

    // R3: a write is visible on the read port one cycle later
    p_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    // R5 and R7: delayed copies trail the inputs by three edges
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> int_ts_out == ts_p3);

    // R6: strobe source chosen by the top control bit
    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cap_mon_out == (cfg_p2[CFG_W-1] ? aux_p3 : ts_p3[MON_IDX]));

    for (genvar n = 0; n < N_SETS; n++) begin : g_set
        // R4: forced level follows the upper select bit
        p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && cfg_p2[4*n+2]) |-> hq_out[n] == cfg_p2[4*n+1]);

        // R2: unforced set copies its selected input
        p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !cfg_p2[4*n+2]) |-> hq_out[n] == ts_p3[chk_idx(n, cfg_p2[4*n +: 2])]);

        for (genvar r = 1; r < N_REPL; r++) begin : g_rep
            // R1: every column carries the same set
            p_replica_r1: assert property (@(posedge clk) disable iff (!rst_n)
                hq_out[r*N_SETS + n] == hq_out[n]);
        end
    end
endmodule

bind ts_distributor ts_distributor_chk #(
    .N_SETS (N_SETS),
    .N_REPL (N_REPL),
    .MON_IDX(MON_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .ts_in      (ts_in),
    .aux_in     (aux_in),
    .hq_out     (hq_out),
    .cap_mon_out(cap_mon_out),
    .int_ts_out (int_ts_out)
);

// File: tb/ts_distributor_test.sv
module ts_distributor_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] ts_in = '0;
    logic        aux_in = 1'b0;
    logic [15:0] hq_out;
    logic        cap_mon_out;
    logic [15:0] int_ts_out;

    int total = 0;
    int bad = 0;

    ts_distributor uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .ts_in      (ts_in),
        .aux_in     (aux_in),
        .hq_out     (hq_out),
        .cap_mon_out(cap_mon_out),
        .int_ts_out (int_ts_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Source table per set, indexed by select code
    int tbl [4][4] = '{'{1, 2, 9, 10}, '{3, 4, 11, 12}, '{5, 6, 13, 14}, '{7, 0, 15, 8}};

    // Behavioural reference: history queues of sampled inputs and control words
    logic [15:0] ts_hist [$];
    logic        aux_hist [$];
    logic [15:0] cfg_hist [$];
    logic [15:0] m_cfg;

    function automatic logic [15:0] exp_hq(input logic [15:0] ts, input logic [15:0] c);
        logic [15:0] v;
        for (int n = 0; n < 4; n++) begin
            logic b;
            int code;
            code = c[4*n +: 2];
            if (c[4*n+2]) b = c[4*n+1];
            else          b = ts[tbl[n][code]];
            for (int r = 0; r < 4; r++) v[4*r + n] = b;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ts_hist  = '{16'h0, 16'h0, 16'h0};
            aux_hist = '{1'b0, 1'b0, 1'b0};
            cfg_hist = '{16'h0, 16'h0};
            m_cfg    = '0;
        end else begin
            ts_hist.push_front(ts_in);
            aux_hist.push_front(aux_in);
            void'(ts_hist.pop_back());
            void'(aux_hist.pop_back());
            cfg_hist.push_front(m_cfg);
            void'(cfg_hist.pop_back());
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] t3, c2, eh;
            logic a3, ec;
            t3 = ts_hist[2];
            a3 = aux_hist[2];
            c2 = cfg_hist[1];
            eh = exp_hq(t3, c2);
            ec = c2[15] ? a3 : t3[10];
            chk("R2 R4 R9 hq_out", hq_out, eh);
            chk("R6 cap_mon_out", {15'b0, cap_mon_out}, {15'b0, ec});
            chk("R5 R7 int_ts_out", int_ts_out, t3);
            chk("R3 cfg_rdata", cfg_rdata, m_cfg);
            for (int k = 0; k < 4; k++)
                for (int r = 1; r < 4; r++)
                    chk("R1 replica", {15'b0, hq_out[4*r+k]}, {15'b0, hq_out[k]});
        end
    end

    task automatic run(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            ts_in  = 16'($urandom);
            aux_in = 1'($urandom);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        ts_in = 16'($urandom); aux_in = 1'($urandom);
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_wdata = 16'($urandom);
        ts_in = 16'($urandom); aux_in = 1'($urandom);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R8: reset state
        chk("R8 reset cfg_rdata", cfg_rdata, 16'h0);
        chk("R8 reset hq_out", hq_out, 16'h0);
        chk("R8 reset int_ts_out", int_ts_out, 16'h0);
        rst_n = 1'b1;

        // R5: single pulse on input 1 with default selection reaches hq_out[0] after three edges
        @(posedge clk); #1; ts_in = 16'h0002;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); chk("R5 latency before third edge", hq_out, 16'h0);
        @(negedge clk); chk("R5 latency at third edge", hq_out, 16'h1111);

        // R2 R4 R9: every set, every code, with and without force
        for (int n = 0; n < 4; n++)
            for (int code = 0; code < 4; code++)
                for (int f = 0; f < 2; f++) begin
                    logic [15:0] w;
                    w = 16'($urandom);
                    w[4*n +: 3] = {1'(f), 2'(code)};
                    write_cfg(w);
                    run(6);
                end

        // R6: both strobe sources
        write_cfg(16'h0000); run(20);
        write_cfg(16'h8000); run(20);
        // R9: unused bits set, result must match the same word without them
        write_cfg(16'h0888); run(10);

        // Back-to-back writes with random traffic
        for (int i = 0; i < 200; i++) begin
            if (i % 3 == 0) write_cfg(16'($urandom));
            else run(1);
        end

        run(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule